// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Model

This block is a synthesizable, device-side model of the 3-wire serial port of a delta-sigma converter. The serial clock is always supplied by the host, and chip select may be held low permanently. Internally the model moves through three phases: converting, sleeping with a result ready, and shifting data out. While a conversion runs and the port is selected, the serial data output reads high as an in-band end-of-conversion flag. When the conversion finishes, the flag drops low and a 32-bit output word holding the new result is latched.

The host then clocks the word out, most significant bit first. On the same clock edges it shifts in an 8-bit configuration byte. A new conversion begins after the 32nd falling clock edge, or at once if the host deselects the port partway through a read. A configuration byte is accepted only when all eight bits have arrived. The conversion itself is represented by a cycle counter of programmable length and a 24-bit result input. The serial inputs are brought into the system clock domain through two-flop synchronizers before their edges are detected.

The clock mode is taken from the serial clock level when reset ends. Only external-clock operation is modelled. If the serial clock is high at that moment, the port stays inert.

Top module: `dsadc_serial_port`

## Requirements
- R1: After reset with the serial clock low, `ext_mode_o` is 1 and `cfg_o` equals the parameter `CFG_INIT` (default 0x00).
- R2: If the serial clock is high when reset ends, `ext_mode_o` is 0 and `sdo_oe_o` stays 0 whatever the other inputs do.
- R3: While chip select is high (deselected), `sdo_oe_o` is 0. While it is low, `sdo_oe_o` is 1 and `sdo_o` carries the conversion status or data.
- R4: After a conversion starts, `sdo_o` reads 1 for exactly `CONV_CYCLES` system clock cycles and then reads 0 (end of conversion).
- R5: At the end of a conversion, `result_i` is sampled into a 32-bit word laid out as bit 31 = 0 (end-of-conversion flag), bit 30 = 0, bits 29..6 = result bits 23..0, bits 5..0 = 0.
- R6: The word is presented most significant bit first. Bit 31 is on `sdo_o` before the first falling serial clock edge, and each falling edge advances `sdo_o` to the next lower bit.
- R7: On each rising serial clock edge, one bit of `sdi_i` is taken. The first bit lands in `cfg_o[7]` and the eighth in `cfg_o[0]`. Rising edges after the eighth do not affect the configuration.
- R8: After the 32nd falling edge, a new conversion starts and `sdo_o` reads 1.
- R9: If chip select rises after the first rising serial clock edge and before the 32nd falling edge, the read ends and a new conversion starts at once.
- R10: If that abort comes before the eighth configuration bit, `cfg_o` keeps its previous value. If all eight bits came first, the new byte is in force.
- R11: Deselecting and reselecting while the result waits, before any rising serial clock edge, does not discard the result. A later read returns the full word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release ends power-on |
| sck_i | input | 1 | Serial clock from host |
| cs_n_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial configuration input |
| result_i | input | 24 | Conversion result, sampled when a conversion ends |
| sdo_o | output | 1 | Serial output: status flag or data bit |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o`; 0 means high impedance |
| cfg_o | output | 8 | Committed configuration byte |
| ext_mode_o | output | 1 | 1 when external serial clock mode was selected at reset |

## Verification
Full 32-bit reads are run with random result values and random configuration bytes. Comparing every shifted bit separates the bit ordering, the padding and the result sampling point. Reads are also aborted at random edge counts on both sides of the eighth rising edge. This shows whether a partial configuration is discarded or committed, and whether the abort restarts conversion. Directed cases cover a deselect while the result waits, exact conversion length after a complete read, and power-up with the serial clock held high.

// File: rtl/dsadc_serial_port.sv
module dsadc_serial_port #(
  parameter int          CONV_CYCLES = 200,
  parameter int          RES_W       = 24,
  parameter int          CFG_W       = 8,
  parameter int          WORD_W      = 32,
  parameter logic [7:0]  CFG_INIT    = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             ext_mode_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES);
  localparam int BC_W  = $clog2(WORD_W);
  localparam int RC_W  = $clog2(CFG_W + 1);
  localparam int PAD_W = WORD_W - 2 - RES_W;

  localparam logic [2:0] S_INIT  = 3'd0;
  localparam logic [2:0] S_CONV  = 3'd1;
  localparam logic [2:0] S_READY = 3'd2;
  localparam logic [2:0] S_OUT   = 3'd3;
  localparam logic [2:0] S_IDLE  = 3'd4;

  logic [2:0]        sck_s, cs_s;
  logic [1:0]        sdi_s;
  logic [2:0]        st;
  logic [1:0]        ini;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [BC_W-1:0]   bcnt;
  logic [RC_W-1:0]   rcnt;
  logic [CFG_W-1:0]  cfg_sh;

  wire sel      = ~cs_s[1];
  wire sck_rise = sel & sck_s[1] & ~sck_s[2];
  wire sck_fall = sel & ~sck_s[1] & sck_s[2];
  wire cs_rise  = cs_s[1] & ~cs_s[2];
  wire take_bit = sck_rise & (rcnt < RC_W'(CFG_W));
  wire [CFG_W-1:0] cfg_nxt = {cfg_sh[CFG_W-2:0], sdi_s[1]};

  assign sdo_oe_o = ext_mode_o & sel & (st != S_INIT);
  assign sdo_o    = (st == S_CONV) ? 1'b1 : shreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s      <= '0;
      cs_s       <= '1;
      sdi_s      <= '0;
      st         <= S_INIT;
      ini        <= '0;
      ext_mode_o <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      bcnt       <= '0;
      rcnt       <= '0;
      cfg_sh     <= '0;
      cfg_o      <= CFG_INIT;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      cs_s  <= {cs_s[1:0], cs_n_i};
      sdi_s <= {sdi_s[0], sdi_i};
      if ((st == S_READY || st == S_OUT) && take_bit) begin
        cfg_sh <= cfg_nxt;
        rcnt   <= rcnt + 1'b1;
        if (rcnt == RC_W'(CFG_W - 1)) cfg_o <= cfg_nxt;
      end
      case (st)
        S_INIT: begin
          ini <= ini + 1'b1;
          if (ini == 2'd3) begin
            ext_mode_o <= ~sck_s[1];
            st         <= sck_s[1] ? S_IDLE : S_CONV;
            cnt        <= '0;
          end
        end
        S_CONV: begin
          if (cnt == CNT_W'(CONV_CYCLES - 1)) begin
            st    <= S_READY;
            shreg <= {2'b00, result_i, {PAD_W{1'b0}}};
            bcnt  <= '0;
            rcnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_READY: if (sck_rise) st <= S_OUT;
        S_OUT: begin
          if (cs_rise) begin
            st  <= S_CONV;
            cnt <= '0;
          end else if (sck_fall) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            bcnt  <= bcnt + 1'b1;
            if (bcnt == BC_W'(WORD_W - 1)) begin
              st  <= S_CONV;
              cnt <= '0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsadc_serial_port_chk.sv
module dsadc_serial_port_chk #(
  parameter int RES_W  = 24,
  parameter int WORD_W = 32,
  parameter int CFG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_i,
  input logic              sdo_oe_o,
  input logic              ext_mode_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [RES_W-1:0]  result_i,
  input logic [2:0]        st,
  input logic [WORD_W-1:0] shreg
);
  localparam logic [2:0] C_INIT  = 3'd0;
  localparam logic [2:0] C_CONV  = 3'd1;
  localparam logic [2:0] C_READY = 3'd2;
  localparam logic [2:0] C_OUT   = 3'd3;

  AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o); // R3

  AST_RESULT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_CONV && st == C_READY) |->
      (shreg[WORD_W-1 -: 2] == 2'b00 && shreg[WORD_W-3 -: RES_W] == $past(result_i))); // R5

  AST_CFG_HOLD_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_CONV) |=> $stable(cfg_o)); // R10

  AST_OUT_EXIT_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_OUT && st != C_OUT) |-> st == C_CONV); // R8

  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != C_INIT && st != C_INIT) |-> $stable(ext_mode_o)); // R1

  AST_READY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_READY && $past(st) != C_READY) |-> $past(st) == C_CONV); // R4
endmodule

bind dsadc_serial_port dsadc_serial_port_chk #(.RES_W(RES_W), .WORD_W(WORD_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sdo_oe_o(sdo_oe_o), .ext_mode_o(ext_mode_o),
  .cfg_o(cfg_o), .result_i(result_i), .st(st), .shreg(shreg)
);

// File: tb/tb_dsadc_serial_port.sv
module tb_dsadc_serial_port;
  localparam int CONV = 60;
  localparam int HALF = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sck = 0, cs_n = 0, sdi = 0;
  logic [23:0] res = 0;
  logic        sdo, sdo_oe, ext_mode;
  logic [7:0]  cfg;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dsadc_serial_port #(.CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .sdi_i(sdi), .result_i(res),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg), .ext_mode_o(ext_mode)
  );

  function automatic logic [31:0] exp_word(input logic [23:0] r);
    return {2'b00, r, 6'b000000};
  endfunction

  function automatic logic [31:0] top_mask(input int k);
    logic [31:0] m = '0;
    for (int i = 0; i < k; i++) m[31-i] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_eoc(output int cyc);
    cyc = 0;
    @(negedge clk);
    while (!(sdo_oe && sdo == 1'b0) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic shift(input int n, input logic [7:0] c, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sdi = (i < 8) ? c[7-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      got[31-i] = sdo;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic conv_len(output int hi);
    int w = 0;
    hi = 0;
    @(negedge clk);
    while (sdo !== 1'b1 && w < 100) begin @(negedge clk); w++; end
    while (sdo === 1'b1 && hi < 2000) begin @(negedge clk); hi++; end
  endtask

  task automatic do_reset(input logic sck_lvl);
    rst_n = 0; sck = sck_lvl; cs_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    sck = 0;
  endtask

  logic [23:0] loaded;
  logic [7:0]  cur_cfg;

  task automatic after_eoc();
    int c;
    wait_eoc(c);
    loaded = res;
    res = 24'($urandom);
  endtask

  initial begin
    logic [31:0] got;
    logic [7:0]  nc;
    int          hi, k;
    void'($urandom(32'd2024));
    res = 24'hA5C3F1;
    do_reset(1'b0);
    chk("R1 ext mode", {31'd0, ext_mode}, 32'd1);
    chk("R1 cfg init", {24'd0, cfg}, 32'h00);
    cur_cfg = 8'h00;
    chk("R3 oe selected", {31'd0, sdo_oe}, 32'd1);
    chk("R4 busy flag", {31'd0, sdo}, 32'd1);
    after_eoc();

    for (int it = 0; it < 8; it++) begin
      nc = 8'($urandom);
      shift(32, nc, got);
      chk("R5 R6 word", got, exp_word(loaded));
      cur_cfg = nc;
      chk("R7 cfg", {24'd0, cfg}, {24'd0, cur_cfg});
      conv_len(hi);
      chk("R4 R8 conv len", hi, CONV);
      loaded = res;
      res = 24'($urandom);
    end

    for (int it = 0; it < 10; it++) begin
      k = (it == 0) ? 5 : (it == 1) ? 8 : (it == 2) ? 7 : $urandom_range(31, 1);
      nc = 8'($urandom);
      shift(k, nc, got);
      chk("R6 partial word", got & top_mask(k), exp_word(loaded) & top_mask(k));
      @(negedge clk); cs_n = 1;
      repeat (6) @(negedge clk);
      chk("R3 hiz", {31'd0, sdo_oe}, 32'd0);
      if (k >= 8) cur_cfg = nc;
      chk("R10 cfg after abort", {24'd0, cfg}, {24'd0, cur_cfg});
      cs_n = 0;
      repeat (5) @(negedge clk);
      chk("R9 restart", {30'd0, sdo_oe, sdo}, 32'd3);
      after_eoc();
    end

    @(negedge clk); cs_n = 1;
    repeat (20) @(negedge clk);
    cs_n = 0;
    repeat (5) @(negedge clk);
    chk("R11 eoc kept", {30'd0, sdo_oe, sdo}, 32'd2);
    shift(32, cur_cfg, got);
    chk("R11 word", got, exp_word(loaded));

    do_reset(1'b1);
    chk("R2 int mode", {31'd0, ext_mode}, 32'd0);
    repeat (2 * CONV) @(negedge clk);
    sck = 1; repeat (HALF) @(negedge clk); sck = 0; repeat (HALF) @(negedge clk);
    chk("R2 oe off", {31'd0, sdo_oe}, 32'd0);

    do_reset(1'b0);
    chk("R1 ext again", {31'd0, ext_mode}, 32'd1);
    done = 1;
  end

  initial begin
    int t = 0;
    while (!done && t < 150000) begin @(posedge clk); t++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule